// File: doc/BRIEF.md
# Configuration Download Security Controller

This block oversees configuration downloads into a programmable-logic fabric. A two-bit mode input picks master serial, slave serial cascade, or one of two factory-test codes. A download-start request, qualified as a normal load or a check pass, opens a download. The download consumes a fixed number of bytes from the configuration stream. The first byte of the stream is the control byte. At the end of a normal download it is committed to a control register. Its bits decide whether the configuration logic takes over the chip-select-out pin and the check pin during later downloads. One bit of it is a security lock.

The lock is sticky. The download that sets it finishes normally. After that, every download request is refused at once: the INIT pin is pulled low, CON is left released, and nothing else happens. Commits to the control register are frozen as well. Only a power-on reset or a manual reset clears the lock.

INIT and CON are modelled as active-low open-drain pins. An output high means the block pulls that pin low.

Top module: `cfg_guard`

## Requirements
- R1: After either reset, the outputs busy, conHold, initAssert, csoutOwn, checkOwn, masterMode, modeErr and locked are 0, and ctrlWord is 8'h00.
- R2: A start request in an idle cycle with modeSel = 2'b00 (master serial) or 2'b01 (slave serial cascade) opens a download on the next edge. masterMode reads 1 for 2'b00 and 0 for 2'b01.
- R3: A start request in an idle cycle with modeSel = 2'b10 or 2'b11 sets modeErr on the next edge and opens no download. modeErr is cleared by the next accepted start.
- R4: busy and conHold are 1 from the edge after an accepted start until the edge that takes the 8th byte (byteValid high while busy). byteValid outside a download has no effect.
- R5: The first byte of a download is the control byte. Bit 2 set means the block leaves the chip-select-out pin alone. csoutOwn equals busy when the committed bit 2 is 0, and stays 0 when it is 1.
- R6: Bit 3 of the control byte set releases the check pin. checkOwn equals busy when the committed bit 3 is 0, and stays 0 when it is 1.
- R7: A normal download commits its control byte to ctrlWord on the edge that takes its last byte. A download whose control byte has bit 4 set runs for all 8 bytes like any other. locked (bit 4 of ctrlWord) reads 1 after that edge.
- R8: While locked is 1, a start request of either kind sets initAssert on the next edge. busy, conHold and ownership stay 0, and initAssert stays 1 until a reset.
- R9: While locked is 1, ctrlWord cannot change. It returns to 8'h00 only on a low porN or a low manRstN.
- R10: A check download (checkMode = 1 at start) consumes its 8 bytes but does not commit the control byte.
- R11: A start request while busy is ignored. This includes the cycle in which the last byte is taken; the byte count is not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| manRstN | input | 1 | Manual reset, active low, asynchronous |
| modeSel | input | 2 | Mode pins {high, low} |
| startReq | input | 1 | Download start request |
| checkMode | input | 1 | 1 = check download, 0 = normal download, sampled with startReq |
| byteValid | input | 1 | Stream byte present |
| byteData | input | 8 | Stream byte |
| busy | output | 1 | Download in progress |
| conHold | output | 1 | 1 = CON pin held low |
| initAssert | output | 1 | 1 = INIT pin pulled low (refused download) |
| csoutOwn | output | 1 | Configuration logic owns the chip-select-out pin |
| checkOwn | output | 1 | Configuration logic owns the check pin |
| masterMode | output | 1 | Current download is master serial |
| modeErr | output | 1 | Last request named a reserved mode |
| locked | output | 1 | Security lock committed |
| ctrlWord | output | 8 | Committed control byte |

## Verification
Two events can land on the same edge: the last byte of the download that sets the lock, and a fresh start request. The bench raises startReq together with the final byteValid of a lock-setting download. It then expects the request to be dropped, with busy low, initAssert low and locked high on the next sample. It also expects the following request to be refused with initAssert high. A second pairing is a start request while a download is under way. This is judged by the download still ending exactly at its 8th byte.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
  typedef enum logic [1:0] {
    MODE_MASTER = 2'b00,
    MODE_SLAVE  = 2'b01,
    MODE_TESTA  = 2'b10,
    MODE_TESTB  = 2'b11
  } cfgMode_e;

  typedef enum logic {ST_IDLE, ST_LOAD} ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic startAcc;
    logic byteAcc;
    logic commit;
  } dpStrobe_t;

  localparam int CASC_OFF_BIT  = 2;
  localparam int CHECK_OFF_BIT = 3;
  localparam int LOCK_BIT      = 4;
endpackage

// File: rtl/cfg_guard_dp.sv
module cfg_guard_dp
  import cfg_guard_pkg::*;
#(
  parameter int NUM_BYTES = 8,
  parameter int BYTE_W    = 8,
  parameter int CTRL_IDX  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [BYTE_W-1:0] byteData,
  output logic              lastByte,
  output logic [BYTE_W-1:0] ctrlWord
);
  localparam int CNT_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NUM_BYTES - 1);
  localparam logic [CNT_W-1:0] CTRL_CNT = CNT_W'(CTRL_IDX);

  logic [CNT_W-1:0]  byteCnt;
  logic [BYTE_W-1:0] shadowByte;
  logic [BYTE_W-1:0] nextShadow;

  assign lastByte = (byteCnt == LAST_CNT);

  // the control byte may itself be the last one, so build the commit value here
  always_comb begin
    nextShadow = shadowByte;
    if (strobe.byteAcc && byteCnt == CTRL_CNT) nextShadow = byteData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt    <= '0;
      shadowByte <= '0;
    end else begin
      if (strobe.startAcc)     byteCnt <= '0;
      else if (strobe.byteAcc) byteCnt <= lastByte ? '0 : byteCnt + 1'b1;
      shadowByte <= nextShadow;
    end
  end

  // committed register: frozen once the lock bit is in it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlWord <= '0;
    else if (strobe.commit && !ctrlWord[LOCK_BIT]) ctrlWord <= nextShadow;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= LAST_CNT); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWord[LOCK_BIT] |=> ctrlWord[LOCK_BIT]); // R9
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrlWord[LOCK_BIT]) |-> $stable(ctrlWord)); // R9
endmodule

// File: rtl/cfg_guard_ctrl.sv
module cfg_guard_ctrl
  import cfg_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic [1:0] modeSel,
  input  logic      startReq,
  input  logic      checkMode,
  input  logic      byteValid,
  input  logic      lastByte,
  input  logic      lockFlag,
  input  logic      cascOff,
  input  logic      checkOff,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      initAssert,
  output logic      modeErr,
  output logic      masterMode,
  output logic      csoutOwn,
  output logic      checkOwn
);
  ctlState_e state;
  logic      isCheck;
  logic      idleReq;
  logic      reservedReq;
  cfgMode_e  reqMode;

  assign reqMode     = cfgMode_e'(modeSel);
  assign idleReq     = (state == ST_IDLE) && startReq;
  assign reservedReq = (reqMode == MODE_TESTA) || (reqMode == MODE_TESTB);
  assign busy        = (state == ST_LOAD);
  assign csoutOwn    = busy && !cascOff;
  assign checkOwn    = busy && !checkOff;

  always_comb begin
    strobe          = '0;
    strobe.startAcc = idleReq && !reservedReq && !lockFlag;
    strobe.byteAcc  = busy && byteValid;
    strobe.commit   = busy && byteValid && lastByte && !isCheck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      isCheck    <= 1'b0;
      initAssert <= 1'b0;
      modeErr    <= 1'b0;
      masterMode <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            if (reservedReq) begin
              modeErr <= 1'b1;
            end else if (lockFlag) begin
              initAssert <= 1'b1;
            end else begin
              state      <= ST_LOAD;
              modeErr    <= 1'b0;
              isCheck    <= checkMode;
              masterMode <= (reqMode == MODE_MASTER);
            end
          end
        end
        ST_LOAD: begin
          if (byteValid && lastByte) begin
            state      <= ST_IDLE;
            masterMode <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RESERVED_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (idleReq && reservedReq) |=> (modeErr && !busy)); // R3
  AST_LOCK_REFUSE: assert property (@(posedge clk) disable iff (!rstN)
    (idleReq && !reservedReq && lockFlag) |=> (initAssert && !busy)); // R8
  AST_NO_INIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !initAssert); // R8
  AST_OWN_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (csoutOwn || checkOwn || masterMode) |-> busy); // R5
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && !byteValid) |=> busy); // R11
endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
  import cfg_guard_pkg::*;
#(
  parameter int NUM_BYTES = 8,
  parameter int BYTE_W    = 8,
  parameter int CTRL_IDX  = 0
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              manRstN,
  input  logic [1:0]        modeSel,
  input  logic              startReq,
  input  logic              checkMode,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  output logic              busy,
  output logic              conHold,
  output logic              initAssert,
  output logic              csoutOwn,
  output logic              checkOwn,
  output logic              masterMode,
  output logic              modeErr,
  output logic              locked,
  output logic [BYTE_W-1:0] ctrlWord
);
  logic      rstN;
  logic      lastByte;
  dpStrobe_t strobe;

  assign rstN    = porN && manRstN;
  assign conHold = busy;
  assign locked  = ctrlWord[LOCK_BIT];

  cfg_guard_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeSel    (modeSel),
    .startReq   (startReq),
    .checkMode  (checkMode),
    .byteValid  (byteValid),
    .lastByte   (lastByte),
    .lockFlag   (ctrlWord[LOCK_BIT]),
    .cascOff    (ctrlWord[CASC_OFF_BIT]),
    .checkOff   (ctrlWord[CHECK_OFF_BIT]),
    .strobe     (strobe),
    .busy       (busy),
    .initAssert (initAssert),
    .modeErr    (modeErr),
    .masterMode (masterMode),
    .csoutOwn   (csoutOwn),
    .checkOwn   (checkOwn)
  );

  cfg_guard_dp #(
    .NUM_BYTES (NUM_BYTES),
    .BYTE_W    (BYTE_W),
    .CTRL_IDX  (CTRL_IDX)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .byteData (byteData),
    .lastByte (lastByte),
    .ctrlWord (ctrlWord)
  );
endmodule

// File: tb/test_cfg_guard.sv
module test_cfg_guard;
  logic       clk = 1'b0;
  logic       porN, manRstN, startReq, checkMode, byteValid;
  logic [1:0] modeSel;
  logic [7:0] byteData;
  logic       busy, conHold, initAssert, csoutOwn, checkOwn, masterMode, modeErr, locked;
  logic [7:0] ctrlWord;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  cfg_guard i_cfg_guard (
    .clk(clk), .porN(porN), .manRstN(manRstN), .modeSel(modeSel),
    .startReq(startReq), .checkMode(checkMode), .byteValid(byteValid),
    .byteData(byteData), .busy(busy), .conHold(conHold), .initAssert(initAssert),
    .csoutOwn(csoutOwn), .checkOwn(checkOwn), .masterMode(masterMode),
    .modeErr(modeErr), .locked(locked), .ctrlWord(ctrlWord)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doStart(logic [1:0] m, logic chkSel);
    modeSel = m; checkMode = chkSel; startReq = 1'b1;
    tick();
    startReq = 1'b0;
  endtask

  // send n stream bytes, first one is the control byte
  task automatic sendBytes(logic [7:0] ctrlB, int n);
    for (int i = 0; i < n; i++) begin
      byteValid = 1'b1;
      byteData  = (i == 0) ? ctrlB : 8'hA5;
      tick();
    end
    byteValid = 1'b0;
  endtask

  task automatic pulseRst(bit usePor);
    if (usePor) porN = 1'b0; else manRstN = 1'b0;
    tick();
    porN = 1'b1; manRstN = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);           chk("R1 conHold", conHold, 0);
    chk("R1 initAssert", initAssert, 0); chk("R1 csoutOwn", csoutOwn, 0);
    chk("R1 checkOwn", checkOwn, 0);   chk("R1 masterMode", masterMode, 0);
    chk("R1 modeErr", modeErr, 0);     chk("R1 locked", locked, 0);
    chk("R1 ctrlWord", ctrlWord, 0);
  endtask

  task automatic t_master();
    sendBytes(8'h1C, 3);                      // idle bytes: no effect (R4)
    chk("R4 idle bytes busy", busy, 0);
    chk("R4 idle bytes ctrlWord", ctrlWord, 0);
    doStart(2'b00, 1'b0);
    chk("R2 master busy", busy, 1);
    chk("R2 master masterMode", masterMode, 1);
    chk("R4 conHold", conHold, 1);
    chk("R5 csoutOwn default", csoutOwn, 1);
    chk("R6 checkOwn default", checkOwn, 1);
    sendBytes(8'h00, 7);
    chk("R4 busy after 7", busy, 1);
    sendBytes(8'hA5, 1);
    chk("R4 busy after 8", busy, 0);
    chk("R4 conHold after 8", conHold, 0);
    chk("R5 csoutOwn idle", csoutOwn, 0);
  endtask

  task automatic t_slave();
    doStart(2'b01, 1'b0);
    chk("R2 slave busy", busy, 1);
    chk("R2 slave masterMode", masterMode, 0);
    sendBytes(8'h0C, 3);
    doStart(2'b00, 1'b0);                     // ignored while busy (R11)
    chk("R11 masterMode unchanged", masterMode, 0);
    sendBytes(8'hA5, 4);
    chk("R11 busy after 7", busy, 1);
    sendBytes(8'hA5, 1);
    chk("R11 busy ends at 8", busy, 0);
    chk("R7 commit 0C", ctrlWord, 8'h0C);
    doStart(2'b00, 1'b0);
    chk("R5 csout released", csoutOwn, 0);
    chk("R6 check released", checkOwn, 0);
    sendBytes(8'h04, 8);
    doStart(2'b01, 1'b0);
    chk("R5 csout released bit2", csoutOwn, 0);
    chk("R6 check owned bit3 clear", checkOwn, 1);
    sendBytes(8'h00, 8);
    chk("R7 commit 00", ctrlWord, 0);
  endtask

  task automatic t_reserved();
    doStart(2'b10, 1'b0);
    chk("R3 modeErr 10", modeErr, 1);
    chk("R3 busy 10", busy, 0);
    chk("R3 conHold 10", conHold, 0);
    doStart(2'b11, 1'b0);
    chk("R3 modeErr 11", modeErr, 1);
    chk("R3 busy 11", busy, 0);
    doStart(2'b00, 1'b0);
    chk("R3 modeErr cleared", modeErr, 0);
    chk("R3 busy valid", busy, 1);
    sendBytes(8'h00, 8);
  endtask

  task automatic t_check();
    doStart(2'b00, 1'b1);
    chk("R10 check busy", busy, 1);
    sendBytes(8'h1C, 8);
    chk("R10 check done", busy, 0);
    chk("R10 no commit", ctrlWord, 0);
    chk("R10 not locked", locked, 0);
    doStart(2'b00, 1'b0);
    chk("R10 csout still owned", csoutOwn, 1);
    chk("R10 check still owned", checkOwn, 1);
    sendBytes(8'h00, 8);
  endtask

  task automatic t_lock();
    doStart(2'b01, 1'b0);
    sendBytes(8'h18, 7);
    chk("R7 lock download busy", busy, 1);
    chk("R7 no early lock", locked, 0);
    byteValid = 1'b1; byteData = 8'hA5; startReq = 1'b1; modeSel = 2'b00; checkMode = 1'b0;
    tick();                                    // final byte and start together
    byteValid = 1'b0; startReq = 1'b0;
    chk("R11 same-cycle start dropped", busy, 0);
    chk("R7 locked", locked, 1);
    chk("R7 no init on own download", initAssert, 0);
    chk("R7 commit 18", ctrlWord, 8'h18);
    doStart(2'b00, 1'b0);
    chk("R8 initAssert", initAssert, 1);
    chk("R8 busy", busy, 0);
    chk("R8 conHold", conHold, 0);
    chk("R8 csoutOwn", csoutOwn, 0);
    sendBytes(8'h00, 8);
    chk("R8 initAssert holds", initAssert, 1);
    chk("R9 ctrlWord frozen", ctrlWord, 8'h18);
    doStart(2'b01, 1'b1);
    chk("R8 check refused", busy, 0);
    chk("R8 init after check", initAssert, 1);
  endtask

  task automatic t_resets();
    pulseRst(1'b0);
    chk("R9 manual clears lock", locked, 0);
    chk("R9 manual clears init", initAssert, 0);
    chk("R9 manual ctrlWord", ctrlWord, 0);
    doStart(2'b00, 1'b0);
    chk("R9 start after manual", busy, 1);
    sendBytes(8'hF3, 8);
    chk("R9 relocked with reserved bits", ctrlWord, 8'hF3);
    pulseRst(1'b1);
    chk("R9 por clears lock", locked, 0);
    chk("R9 por ctrlWord", ctrlWord, 0);
    chk("R1 por busy", busy, 0);
  endtask

  initial begin
    porN = 1'b0; manRstN = 1'b1; modeSel = 2'b00; startReq = 1'b0;
    checkMode = 1'b0; byteValid = 1'b0; byteData = 8'h00;
    tick(); tick();
    porN = 1'b1;
    tick();
    t_reset();
    t_master();
    t_slave();
    t_reserved();
    t_check();
    t_lock();
    t_resets();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule